// File: doc/BRIEF.md
# Manchester Word Encoder with Sync

This block turns one data word into a framed Manchester II line signal. It runs on a single send clock at twice the bit rate and brings out a derived bit-rate shift clock, `bit_clk`, which is low in the first half and high in the second half of each bit time. A frame starts at the end of a bit time in which `enc_en` is high. The frame then lasts 20 bit times: a three-bit-time sync, 16 data bits and one odd-parity bit. The sync has one polarity for a command word and the opposite polarity for a data word, and `sync_sel` picks which one.

The word arrives serially, most significant bit first, through a pull interface. `sd_req` is the ready side of this interface. The source has no valid signal and cannot apply back-pressure. While `sd_req` is high, the source must present a fresh bit on `ser_in` in every bit time, and the block takes it at the end of that bit time. The block ignores `ser_in` at all other times.

The line is driven through two active-low outputs, one for each line sense. If `enc_en` is still high when the parity bit ends, the next frame follows with no gap. `inhibit_n` silences the line and leaves the sequence running. A synchronous `rst` pulse aborts a frame in progress.

Top module: `manchester_word_enc`

## Requirements
- R1: After reset, and whenever no frame is in progress, `pos_n` and `neg_n` are both 1 and `sd_req` is 0.
- R2: A frame starts only at a send-clock edge where `enc_en` is 1 and `bit_clk` is 1. The first half-bit of the frame appears in the cycle after that edge. If `enc_en` is high while `bit_clk` is 0, no frame starts at that edge.
- R3: The sync occupies the first six half-bits. For a command word (`sync_sel`=1 at the start edge), the line is positive for three half-bits and then negative for three. For a data word (`sync_sel`=0), the order is reversed. A positive line means `pos_n`=0 and `neg_n`=1, and a negative line means `pos_n`=1 and `neg_n`=0.
- R4: `sd_req` is 1 for exactly bit times 2 to 17 of the frame, which is 32 send-clock cycles. In each of these bit times, `ser_in` is sampled at the end of the bit time. `ser_in` has no effect at any other time.
- R5: The bit sampled in bit time n is sent in bit time n+1, covering bit times 3 to 18. A 1 is sent as positive then negative, and a 0 as negative then positive. Each half lasts one send-clock cycle.
- R6: Bit time 19 carries the odd-parity bit, chosen so that the 16 data bits plus this bit hold an odd number of ones. It is coded as in R5.
- R7: If `enc_en` is 1 at the edge that ends the parity bit, the next frame's sync starts in the very next cycle. The new frame uses the `sync_sel` value present at that edge. If `enc_en` is 0, the block returns to idle.
- R8: While `inhibit_n` is 0, both line outputs are 1. The frame timing and the data are unaffected, so a later uninhibited half-bit shows its normal value.
- R9: A send-clock edge with `rst` at 1 aborts any frame. In the next cycle the block is idle, as in R1.
- R10: `bit_clk` toggles on every send-clock edge after reset. Inside a frame it is 0 in the first half and 1 in the second half of each bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Send clock, twice the bit rate |
| rst | input | 1 | Synchronous master reset / abort, active high |
| enc_en | input | 1 | Encode enable, sampled at bit-time ends |
| sync_sel | input | 1 | 1 selects command sync, 0 selects data sync |
| ser_in | input | 1 | Serial NRZ data from the source, MSB first |
| inhibit_n | input | 1 | 0 forces both line outputs inactive |
| bit_clk | output | 1 | Derived bit-rate shift clock |
| sd_req | output | 1 | Data request: source must present a bit each bit time |
| pos_n | output | 1 | Active-low positive line sense |
| neg_n | output | 1 | Active-low negative line sense |

## Verification
The line outputs are decoded without a register from the frame state. Half-bit k of a frame is therefore visible k+1 cycles after the start edge. After a `rst` edge, the idle state is visible one cycle later. `sd_req` and `bit_clk` follow the same one-cycle rule. The bench samples every output at the falling clock edge and steps a half-bit index in lock with those edges. It drives `ser_in`, `enc_en`, `sync_sel` and `inhibit_n` only after sampling, so each expected value is compared in exactly the cycle that its half-bit is due.

// File: rtl/mwe_pkg.sv
package mwe_pkg;
  typedef enum logic [1:0] {
    LVL_IDLE = 2'd0,
    LVL_POS  = 2'd1,
    LVL_NEG  = 2'd2
  } line_lvl_e;
endpackage

// File: rtl/mwe_seq.sv
module mwe_seq #(
  parameter int NSLOT  = 20,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sync_sel,
  output logic              phase,
  output logic              busy,
  output logic [SLOT_W-1:0] slot,
  output logic              cmd,
  output logic              frame_start
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOT - 1);

  logic at_end;
  assign at_end      = busy && (slot == LAST_SLOT);
  // a bit time ends on the edge where phase is 1
  assign frame_start = phase && en && (!busy || at_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      busy  <= 1'b0;
      slot  <= '0;
      cmd   <= 1'b0;
    end else begin
      phase <= ~phase;
      if (frame_start) begin
        busy <= 1'b1;
        slot <= '0;
        cmd  <= sync_sel;
      end else if (phase && busy) begin
        if (at_end) begin
          busy <= 1'b0;
          slot <= '0;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mwe_feed.sv
module mwe_feed #(
  parameter int DATA_W    = 16,
  parameter int SYNC_BITS = 3,
  parameter int SLOT_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase,
  input  logic              busy,
  input  logic [SLOT_W-1:0] slot,
  input  logic              frame_start,
  input  logic              ser_in,
  output logic              sd_req,
  output logic              cur_bit
);
  localparam int FIRST_REQ = SYNC_BITS - 1;
  localparam int LAST_REQ  = FIRST_REQ + DATA_W - 1;
  localparam int PAR_LOAD  = LAST_REQ + 1;

  logic par_acc;

  assign sd_req = busy && (slot >= SLOT_W'(FIRST_REQ)) && (slot <= SLOT_W'(LAST_REQ));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_bit <= 1'b0;
      par_acc <= 1'b0;
    end else begin
      if (frame_start) begin
        par_acc <= 1'b0;
      end else if (phase && sd_req) begin
        cur_bit <= ser_in;
        par_acc <= par_acc ^ ser_in;
      end else if (phase && busy && (slot == SLOT_W'(PAR_LOAD))) begin
        cur_bit <= ~par_acc;  // odd parity over the word
      end
    end
  end
endmodule

// File: rtl/mwe_line.sv
module mwe_line
  import mwe_pkg::*;
#(
  parameter int SYNC_BITS = 3,
  parameter int SLOT_W    = 5
) (
  input  logic              busy,
  input  logic [SLOT_W-1:0] slot,
  input  logic              phase,
  input  logic              cmd,
  input  logic              cur_bit,
  input  logic              inhibit_n,
  output logic              pos_n,
  output logic              neg_n
);
  logic [SLOT_W:0] half_idx;
  logic            positive;
  line_lvl_e       lvl;

  assign half_idx = {slot, phase};

  always_comb begin
    if (slot < SLOT_W'(SYNC_BITS)) begin
      // sync: SYNC_BITS half-bits of one sense, then SYNC_BITS of the other
      positive = (half_idx < (SLOT_W+1)'(SYNC_BITS)) ? cmd : ~cmd;
    end else begin
      positive = phase ? ~cur_bit : cur_bit;
    end
    if (!busy)         lvl = LVL_IDLE;
    else if (positive) lvl = LVL_POS;
    else               lvl = LVL_NEG;
  end

  assign pos_n = !(inhibit_n && (lvl == LVL_POS));
  assign neg_n = !(inhibit_n && (lvl == LVL_NEG));
endmodule

// File: rtl/manchester_word_enc.sv
module manchester_word_enc #(
  parameter int DATA_W    = 16,
  parameter int SYNC_BITS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enc_en,
  input  logic sync_sel,
  input  logic ser_in,
  input  logic inhibit_n,
  output logic bit_clk,
  output logic sd_req,
  output logic pos_n,
  output logic neg_n
);
  localparam int NSLOT  = SYNC_BITS + DATA_W + 1;
  localparam int SLOT_W = $clog2(NSLOT);

  logic              phase, busy, cmd, frame_start, cur_bit;
  logic [SLOT_W-1:0] slot;

  mwe_seq #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst(rst), .en(enc_en), .sync_sel(sync_sel),
    .phase(phase), .busy(busy), .slot(slot), .cmd(cmd),
    .frame_start(frame_start)
  );

  mwe_feed #(.DATA_W(DATA_W), .SYNC_BITS(SYNC_BITS), .SLOT_W(SLOT_W)) u_feed (
    .clk(clk), .rst(rst), .phase(phase), .busy(busy), .slot(slot),
    .frame_start(frame_start), .ser_in(ser_in),
    .sd_req(sd_req), .cur_bit(cur_bit)
  );

  mwe_line #(.SYNC_BITS(SYNC_BITS), .SLOT_W(SLOT_W)) u_line (
    .busy(busy), .slot(slot), .phase(phase), .cmd(cmd), .cur_bit(cur_bit),
    .inhibit_n(inhibit_n), .pos_n(pos_n), .neg_n(neg_n)
  );

  assign bit_clk = phase;
endmodule

// File: rtl/manchester_word_enc_chk.sv
module manchester_word_enc_chk #(
  parameter int REQ_CYC = 32
) (
  input logic clk,
  input logic rst,
  input logic inhibit_n,
  input logic bit_clk,
  input logic sd_req,
  input logic pos_n,
  input logic neg_n
);
  localparam int CW = $clog2(REQ_CYC) + 2;
  logic [CW-1:0] req_run;

  always_ff @(posedge clk) begin
    if (rst || !sd_req)                  req_run <= '0;
    else if (req_run != {CW{1'b1}})      req_run <= req_run + 1'b1;
  end

  // R4: request window never exceeds its length
  assert_req_len_R4: assert property (@(posedge clk) disable iff (rst)
    sd_req |-> (req_run < CW'(REQ_CYC)));

  // R5: never both senses active at once
  assert_one_sense_R5: assert property (@(posedge clk) disable iff (rst)
    !(!pos_n && !neg_n));

  assert_inhibit_R8: assert property (@(posedge clk) disable iff (rst)
    !inhibit_n |-> (pos_n && neg_n));

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pos_n && neg_n && !sd_req));

  assert_bitclk_toggle_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (bit_clk != $past(bit_clk)));
endmodule

bind manchester_word_enc manchester_word_enc_chk #(.REQ_CYC(2*DATA_W)) u_chk (
  .clk(clk), .rst(rst), .inhibit_n(inhibit_n), .bit_clk(bit_clk),
  .sd_req(sd_req), .pos_n(pos_n), .neg_n(neg_n)
);

// File: tb/manchester_word_enc_tb.sv
module manchester_word_enc_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rst, enc_en, sync_sel, ser_in, inhibit_n;
  logic bit_clk, sd_req, pos_n, neg_n;
  int   nvec = 0;
  int   nbad = 0;

  manchester_word_enc u_dut (
    .clk(clk), .rst(rst), .enc_en(enc_en), .sync_sel(sync_sel),
    .ser_in(ser_in), .inhibit_n(inhibit_n), .bit_clk(bit_clk),
    .sd_req(sd_req), .pos_n(pos_n), .neg_n(neg_n)
  );

  task automatic check(input bit ok, input string what);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s", what);
    end
  endtask

  task automatic check_idle(input string tag);
    check(pos_n === 1'b1 && neg_n === 1'b1 && sd_req === 1'b0,
          $sformatf("%s idle: pos_n=%b neg_n=%b sd_req=%b expected 1 1 0",
                    tag, pos_n, neg_n, sd_req));
  endtask

  // expected line sense (1 = positive) for half-bit k of a frame
  function automatic bit exp_pos(input logic [15:0] w, input bit cmd, input int k);
    int s;
    bit h, b;
    s = k / 2;
    h = (k % 2) == 1;
    if (k < 6) return (k < 3) ? cmd : !cmd;
    if (s < 19) b = w[18 - s];
    else        b = ~^w;
    return h ? !b : b;
  endfunction

  task automatic frame(input logic [15:0] w, input bit cmd, input bit chained,
                       input bit keep, input bit next_cmd, input bit inh_mode,
                       input int abort_k);
    if (!chained) begin
      @(negedge clk);
      while (bit_clk !== 1'b0) @(negedge clk);
      check_idle("R1");
      enc_en   = 1'b1;
      sync_sel = cmd;
      @(negedge clk);
      check(bit_clk === 1'b1 && pos_n === 1'b1 && neg_n === 1'b1,
            $sformatf("R2 no start in first half: bit_clk=%b pos_n=%b neg_n=%b expected 1 1 1",
                      bit_clk, pos_n, neg_n));
    end
    for (int k = 0; k < 40; k++) begin
      int    s;
      bit    p, epn, enn, ereq;
      string tag;
      @(negedge clk);
      s    = k / 2;
      p    = exp_pos(w, cmd, k);
      epn  = inhibit_n ? !p : 1'b1;
      enn  = inhibit_n ? p : 1'b1;
      ereq = (s >= 2 && s <= 17);
      if (!inhibit_n)  tag = "R8";
      else if (s < 3)  tag = "R3";
      else if (s < 19) tag = "R5";
      else             tag = "R6";
      check(pos_n === epn && neg_n === enn,
            $sformatf("%s half %0d word %h: pos_n=%b neg_n=%b expected %b %b",
                      tag, k, w, pos_n, neg_n, epn, enn));
      check(sd_req === ereq,
            $sformatf("R4 half %0d: sd_req=%b expected %b", k, sd_req, ereq));
      check(bit_clk === bit'(k % 2),
            $sformatf("R10 half %0d: bit_clk=%b expected %0d", k, bit_clk, k % 2));
      if (k == abort_k) begin
        rst = 1'b1;
        @(negedge clk);
        rst       = 1'b0;
        enc_en    = 1'b0;
        inhibit_n = 1'b1;
        check_idle("R9");
        return;
      end
      ser_in    = ereq ? w[17 - s] : 1'($urandom % 2);
      inhibit_n = inh_mode ? ($urandom % 3 != 0) : 1'b1;
      if (k == 0) enc_en = 1'b0;
      if (k == 39) begin
        enc_en    = keep;
        sync_sel  = next_cmd;
        inhibit_n = 1'b1;
      end
    end
    if (!keep) begin
      @(negedge clk);
      check_idle("R7");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    bit prev_keep, ncmd;
    void'($urandom(32'h5eed_0412));
    rst = 1'b1; enc_en = 1'b0; sync_sel = 1'b0; ser_in = 1'b0; inhibit_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_idle("R1");
      ser_in = 1'($urandom % 2);  // ignored while idle (R4)
    end
    // directed corners
    frame(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    frame(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    frame(16'h8001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    frame(16'h7FFE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    // back-to-back with alternating sync (R7)
    frame(16'hA5A5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, -1);
    frame(16'h3C96, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, -1);
    frame(16'h0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, -1);
    // inhibit in the middle of a frame (R8)
    frame(16'h5AC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    // abort during data, then a clean frame (R9)
    frame(16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 13);
    frame(16'h4321, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    // constrained random
    prev_keep = 1'b0;
    ncmd      = 1'($urandom % 2);
    for (int i = 0; i < 24; i++) begin
      logic [15:0] w;
      bit          keep, nxt;
      w    = 16'($urandom);
      keep = 1'($urandom % 2);
      nxt  = 1'($urandom % 2);
      frame(w, ncmd, prev_keep, keep, nxt, ($urandom % 4) == 0, -1);
      prev_keep = keep;
      ncmd      = keep ? nxt : 1'($urandom % 2);
    end
    if (prev_keep) begin
      frame(16'hBEEF, ncmd, 1'b1, 1'b0, 1'b0, 1'b0, -1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule